// File: doc/BRIEF.md
# Tapped-Line Frame Capture Receiver

This block receives a serial line by shifting it into a chain of registers, one register per bit period, so that a complete frame is visible across the chain at one time. The line idles high. A frame consists of a run of at least `PRE_LEN` high stop bits, then one low start bit, then `DATA_W` data bits sent least-significant bit first. The chain holds `PRE_LEN + 1 + DATA_W` bits, and tap 0 holds the most recently received bit.

Byte alignment comes from comparing a pattern across the whole chain in parallel, not from a bit counter that a start edge triggers. On every cycle the block compares the chain against the expected layout: every preamble position high and the start position low. When that layout is present, the data taps are copied to the parallel output, and a single-cycle valid strobe marks them.

After a capture, a hold-off window keeps the frame that has just been captured from being matched a second time while it shifts out of the chain. The data sampling reads the chain directly, so no oversampling is used. The data width and the preamble length are parameters.

Top module: `tapline_frame_rx`

## Requirements
- R1: Data bit i of `data_o` is the i-th bit received after the start bit, so the first bit on the line lands in bit 0.
- R2: A capture fires only when the `PRE_LEN` bits received before a low start bit are all high. A frame with fewer preceding high bits produces no strobe, and `data_o` keeps its previous value.
- R3: `valid_o` goes high on the first clock edge after the edge that shifts the last data bit into the chain. `data_o` then keeps the captured value until the next capture or reset.
- R4: `valid_o` is high for exactly one cycle per captured frame.
- R5: After a capture, no further capture fires for `PRE_LEN + DATA_W` cycles, so consecutive strobes are at least `PRE_LEN + 1 + DATA_W` cycles apart. A start bit that arrives after only `PRE_LEN - 1` high bits following a captured frame whose last data bit was 1 is suppressed.
- R6: While `rst_n` is low at a clock edge, `valid_o` and `data_o` are cleared on that edge.
- R7: Reset fills the chain with high bits. A start bit and data sent straight after reset, with no stop bits, are therefore captured.
- R8: Frames sent back to back with exactly `PRE_LEN` stop bits between them are each captured once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Serial line, idle high |
| data_o | output | DATA_W | Captured data word, bit 0 received first |
| valid_o | output | 1 | One-cycle strobe marking a new capture |

## Verification
The bench concentrates on start bits that appear with too few high bits ahead of them. Some of these follow a data word that ends in 0, and a design that checked only part of the preamble would accept them. One follows, by one bit too few, a word that ends in 1; a design without the hold-off window would capture it as a frame. Back-to-back frames with the minimum preamble catch a hold-off window that is one cycle too long, which would drop the second frame. A frame sent with no stop bits straight after reset shows whether reset fills the chain with high bits. Exact strobe timing catches an added pipeline register or a strobe that is more than one cycle wide. A reversed data tap order shows up as bit-swapped words.

// File: rtl/tapline_frame_rx_pkg.sv
// Package: shared sizing helpers for the tapped-line frame receiver.
// Assumes: all sizes are positive and small enough for a flat register chain.
package tapline_frame_rx_pkg;

    // Total chain length: preamble, start bit and data bits.
    function automatic int chain_len_f(input int pre_len, input int data_w);
        return pre_len + 1 + data_w;
    endfunction

    // Width of a counter that can hold the value n.
    function automatic int cnt_width_f(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tfr_tap_chain.sv
// Module: tfr_tap_chain
// Shifts the serial line into a LEN-bit register chain, one bit per clock,
// with tap 0 holding the newest bit.
// Assumes: one clock period equals one bit period; the line idles high, so
// reset fills the chain with ones.
module tfr_tap_chain #(
    parameter int LEN = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_i,
    output logic [LEN-1:0] taps_o
);

    // Shift the newest line bit in at tap 0; reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps_o <= '1;
        end else begin
            taps_o <= {taps_o[LEN-2:0], line_i};
        end
    end

endmodule

// File: rtl/tfr_pattern_match.sv
// Module: tfr_pattern_match
// Compares the whole tap chain against the frame layout: the oldest PRE_LEN
// taps high and the start tap low. Also reorders the data taps so that the
// first bit received lands in bit 0.
// Assumes: taps are indexed newest first; purely combinational.
module tfr_pattern_match #(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 8,
    parameter int LEN     = PRE_LEN + 1 + DATA_W
) (
    input  logic [LEN-1:0]    taps_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] payload_o
);

    localparam int START_POS = DATA_W;

    logic [PRE_LEN-1:0] preamble;

    // Gather the preamble taps that sit just above the start position.
    always_comb preamble = taps_i[LEN-1 -: PRE_LEN];

    // Match needs every preamble tap high and the start tap low together.
    always_comb hit_o = (&preamble) && !taps_i[START_POS];

    // Reverse the data taps: the oldest data tap is the first bit received.
    for (genvar i = 0; i < DATA_W; i++) begin : g_order
        assign payload_o[i] = taps_i[DATA_W-1-i];
    end

endmodule

// File: rtl/tfr_holdoff.sv
// Module: tfr_holdoff
// Passes a pattern hit through as a capture, then blocks further hits for WIN
// cycles so that a captured frame cannot match again while it shifts out.
// Assumes: WIN is the chain length minus one.
module tfr_holdoff #(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic fire_o
);

    localparam int CW = tapline_frame_rx_pkg::cnt_width_f(WIN);

    logic [CW-1:0] remain;

    // A hit becomes a capture only outside the hold-off window.
    always_comb fire_o = hit_i && (remain == '0);

    // Load the window on a capture; otherwise count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (fire_o) begin
            remain <= CW'(WIN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/tapline_frame_rx.sv
// Module: tapline_frame_rx (top)
// Tapped-line frame capture receiver: the chain exposes a whole frame in
// parallel, the matcher finds the preamble and start layout, the hold-off
// stops re-triggering, and an output register presents the word with a
// one-cycle strobe.
// Assumes: one clock per bit, line idles high, synchronous active-low reset.
module tapline_frame_rx #(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int LEN = tapline_frame_rx_pkg::chain_len_f(PRE_LEN, DATA_W);
    localparam int WIN = LEN - 1;

    logic [LEN-1:0]    taps;
    logic              hit;
    logic              fire;
    logic [DATA_W-1:0] payload;

    tfr_tap_chain #(.LEN(LEN)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .taps_o (taps)
    );

    tfr_pattern_match #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN), .LEN(LEN)) u_match (
        .taps_i    (taps),
        .hit_o     (hit),
        .payload_o (payload)
    );

    tfr_holdoff #(.WIN(WIN)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit),
        .fire_o (fire)
    );

    // Register the strobe and hold the captured word until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= fire;
            if (fire) begin
                data_o <= payload;
            end
        end
    end

endmodule

// File: rtl/tapline_frame_rx_chk.sv
// Module: tapline_frame_rx_chk
// Checker bound to the receiver top. It keeps its own history of the line
// and a count of the cycles since the last strobe, and checks the outputs
// against both.
// Assumes: same parameters as the bound instance.
module tapline_frame_rx_chk #(
    parameter int DATA_W  = 8,
    parameter int PRE_LEN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_i,
    input logic [DATA_W-1:0] data_o,
    input logic              valid_o
);

    localparam int LEN = PRE_LEN + 1 + DATA_W;
    localparam int GW  = $clog2(LEN + 1);

    logic [LEN-1:0]    hist;
    logic [DATA_W-1:0] exp_word;
    logic              exp_frame;
    logic [GW-1:0]     gap;

    // Line history in receive order, newest bit at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[LEN-2:0], line_i};
    end

    // Cycles since the last strobe, saturating at the chain length.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap <= GW'(LEN);
        else if (valid_o)          gap <= GW'(1);
        else if (gap != GW'(LEN))  gap <= gap + 1'b1;
    end

    // Expected word and frame layout, taken from the history.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) exp_word[i] = hist[DATA_W-1-i];
        exp_frame = (&hist[LEN-1 -: PRE_LEN]) && !hist[DATA_W];
    end

    // R1: the strobed word matches the history one cycle earlier.
    a_r1_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> data_o == $past(exp_word));

    // R2: a strobe needs the full preamble and start layout one cycle earlier.
    a_r2_full_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(exp_frame));

    // R4: the strobe is never longer than one cycle.
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5: strobes are at least one chain length apart.
    a_r5_holdoff_gap: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> gap >= GW'(LEN));

    // R6: a reset edge clears the outputs.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && data_o == '0));

endmodule

bind tapline_frame_rx tapline_frame_rx_chk #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_i),
    .data_o  (data_o),
    .valid_o (valid_o)
);

// File: tb/tapline_frame_rx_test.sv
// Bench for tapline_frame_rx: a table of frames walked by one loop, then
// directed checks for reset, latency and strobe shape.
module tapline_frame_rx_test;

    localparam int DW = 8;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          line_i;
    logic [DW-1:0] data_o;
    logic          valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] log_q [64];
    int            nlog      = 0;
    int            width_err = 0;
    logic          valid_prev = 1'b0;

    // Table entries are {stop bits before start, data word, captured?}.
    localparam logic [13:0] VEC [NV] = '{
        {5'd8,  8'h5A, 1'b1},
        {5'd8,  8'h00, 1'b1},   // R8: exactly PRE_LEN stop bits, back to back
        {5'd12, 8'hFF, 1'b1},
        {5'd7,  8'h24, 1'b0},   // R5: held off, previous word ends in 1
        {5'd9,  8'h01, 1'b1},
        {5'd7,  8'h3C, 1'b0},   // R2: short preamble
        {5'd8,  8'hA5, 1'b1},
        {5'd3,  8'h80, 1'b0},   // R2: short preamble
        {5'd10, 8'h80, 1'b1},
        {5'd0,  8'h7F, 1'b0},   // R2: no stop bits at all
        {5'd8,  8'hC3, 1'b1}
    };

    always #10 clk = ~clk;

    tapline_frame_rx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    // Log each strobe and count strobes that last longer than one cycle.
    always @(negedge clk) begin
        if (valid_o && nlog < 64) begin
            log_q[nlog] = data_o;
            nlog++;
        end
        if (valid_o && valid_prev) width_err++;
        valid_prev = valid_o;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        line_i = b;
        @(negedge clk);
    endtask

    task automatic send_frame(input int pre, input logic [DW-1:0] d);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < DW; i++) send_bit(d[i]);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int k;
        logic [DW-1:0] exp_list [NV];
        int nexp;

        rst_n  = 1'b0;
        line_i = 1'b1;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R6 reset valid", int'(valid_o), 0);
        check(data_o == '0, "R6 reset data", int'(data_o), 0);
        rst_n = 1'b1;

        // R7 and R3: start plus data at once after reset, exact strobe timing.
        base = nlog;
        send_frame(0, 8'h96);
        check(valid_o == 1'b0, "R3 strobe not early", int'(valid_o), 0);
        @(negedge clk);
        check(valid_o == 1'b1, "R3/R7 strobe after last bit", int'(valid_o), 1);
        check(data_o == 8'h96, "R1/R7 word", int'(data_o), 'h96);
        @(negedge clk);
        check(valid_o == 1'b0, "R4 strobe one cycle", int'(valid_o), 0);
        repeat (20) send_bit(1'b1);
        check(nlog - base == 1, "R7 capture count", nlog - base, 1);

        // Table walk.
        base = nlog;
        nexp = 0;
        for (int v = 0; v < NV; v++) begin
            send_frame(int'(VEC[v][13:9]), VEC[v][8:1]);
            if (VEC[v][0]) begin
                exp_list[nexp] = VEC[v][8:1];
                nexp++;
            end
        end
        repeat (20) send_bit(1'b1);
        check(nlog - base == nexp, "R2 capture count", nlog - base, nexp);
        k = (nlog - base < nexp) ? nlog - base : nexp;
        for (int i = 0; i < k; i++)
            check(log_q[base+i] == exp_list[i], "R1/R2 captured word",
                  int'(log_q[base+i]), int'(exp_list[i]));
        check(log_q[base+1] == 8'h00, "R8 back-to-back second frame", int'(log_q[base+1]), 0);
        check(log_q[base+3] == 8'h01, "R5 held-off frame skipped", int'(log_q[base+3]), 1);
        check(width_err == 0, "R4 strobe width", width_err, 0);
        check(data_o == 8'hC3, "R3 word held", int'(data_o), 'hC3);

        // Reset again: outputs cleared.
        rst_n = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0 && data_o == '0, "R6 reset clears", int'(data_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule